// File: doc/BRIEF.md
# Coprocessor-0 Exception and Interrupt Control

This block keeps the system-control Status, Cause and exception-return address (EPC) registers of a MIPS-I style processor. It services move-to-coprocessor writes and combinational reads at register indices 12 (Status), 13 (Cause) and 14 (EPC). It performs the return-from-exception pop of the Status mode/enable stack. It starts exception entry for a BREAK instruction and for the two software-interrupt bits.

Any write to Cause and any return-from-exception arms a one-cycle re-evaluation of the software-interrupt condition. That condition is true when Status and Cause share a set bit in positions 9:8 and the current interrupt enable (Status bit 0) is set. If it is true, an interrupt is entered on the next clock edge. On every exception entry the block does four things: it pushes the Status stack, records the faulting address and the branch-delay indication, writes the exception code, and presents a one-cycle taken pulse together with the handler vector.

Top module: `cop0_exc_ctrl`

## Requirements
- R1: After reset, Status reads 0x00400000 (boot-vector bit 22 set), Cause and EPC read 0, `exc_taken_o` is low, and any read index other than 12, 13 or 14 returns 0.
- R2: A write to index 12 replaces all 32 bits of Status, and the new value is readable in the following cycle.
- R3: A write to index 13 changes only Cause bits 9:8. Every other Cause bit keeps its value.
- R4: A write to index 14 has no effect. EPC changes only on exception entry.
- R5: A return-from-exception strobe loads Status[3:0] from the old Status[5:2] and leaves Status[31:4] unchanged.
- R6: After an edge that performs a Cause write or an RFE, the next edge enters an interrupt if (Cause & Status & 0x300) != 0 and Status[0] = 1. `exc_taken_o` is then high in the cycle after that edge. A Status write alone never starts an interrupt.
- R7: An interrupt entry clears the exception-code field Cause[6:2] to 0.
- R8: A BREAK strobe enters an exception on the edge that samples it and writes code 9 into Cause[6:2] (Cause low byte 0x24). `exc_taken_o` is high for the following cycle.
- R9: On entry, EPC is `pc_i` and Cause[31] is 0 when `in_delay_i` is low. When `in_delay_i` is high, EPC is `pc_i` minus 4 and Cause[31] is 1.
- R10: On entry, Status[5:0] becomes {old Status[3:0], 2'b00}. Bits 31:6 are unchanged.
- R11: The vector is 0x80000080 when Status bit 22 is clear at entry, and 0xBFC00180 when it is set.
- R12: BREAK has priority over a pending interrupt re-check, which is then dropped. An edge that enters an exception ignores a register write or an RFE. An RFE ignores a register write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rfe_i | input | 1 | Return-from-exception strobe |
| brk_i | input | 1 | BREAK instruction strobe |
| pc_i | input | 32 | Address of the current instruction |
| in_delay_i | input | 1 | Current instruction sits in a branch delay slot |
| exc_taken_o | output | 1 | One-cycle exception-entry pulse |
| exc_vector_o | output | 32 | Handler address, valid with the pulse |
| epc_o | output | 32 | Exception return address |

## Verification
A wrong Status stack shows up as wrong read data in the cycle after the RFE or entry edge. It also shows up as a wrong or missing interrupt pulse two cycles after a Cause write, because the enable bit gates the re-check. A stale re-check flag or an incorrect Cause mask shows as an extra or missing `exc_taken_o`, with the wrong code or delay bit in the next Cause read. EPC and vector errors appear at the ports in the cycle the pulse is high.

// File: rtl/cop0_exc_pkg.sv
package cop0_exc_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned IDX_W     = 5;
   localparam int unsigned CODE_W    = 5;
   localparam int unsigned CODE_LO   = 2;
   localparam int unsigned SWI_LO    = 8;
   localparam int unsigned SWI_W     = 2;
   localparam int unsigned BD_POS    = 31;
   localparam int unsigned BEV_POS   = 22;
   localparam int unsigned STK_W     = 6;

   typedef enum logic [1:0] {
      ENTRY_NONE = 2'd0,
      ENTRY_SWI  = 2'd1,
      ENTRY_BRK  = 2'd2
   } entry_kind_e;

   localparam logic [CODE_W-1:0] CODE_INT = 5'd0;
   localparam logic [CODE_W-1:0] CODE_BRK = 5'd9;
endpackage

// File: rtl/cop0_status_reg.sv
module cop0_status_reg
   import cop0_exc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STACK_W = 6,
   parameter logic [31:0] RST_VAL = 32'h0040_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop_en,
   input  logic              push_en,
   output logic [DATA_W-1:0] status_q
);
   localparam int unsigned POP_W = STACK_W - 2;

   generate
      if (STACK_W < 4 || STACK_W > DATA_W || (STACK_W % 2) != 0) begin : g_bad_stack
         $error("cop0_status_reg: STACK_W must be even, >= 4 and <= DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] status_d;

   always_comb begin
      status_d = status_q;
      if (push_en) begin
         status_d[STACK_W-1:0] = {status_q[POP_W-1:0], 2'b00};
      end else if (pop_en) begin
         status_d[POP_W-1:0] = status_q[STACK_W-1:2];
      end else if (wr_en) begin
         status_d = wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= RST_VAL[DATA_W-1:0];
      else        status_q <= status_d;
   end

   // R5
   rfe_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !push_en) |=>
         (status_q[POP_W-1:0] == $past(status_q[STACK_W-1:2])) &&
         (status_q[DATA_W-1:POP_W] == $past(status_q[DATA_W-1:POP_W])));

   // R10
   entry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |=>
         (status_q[1:0] == 2'b00) &&
         (status_q[STACK_W-1:2] == $past(status_q[POP_W-1:0])) &&
         (status_q[DATA_W-1:STACK_W] == $past(status_q[DATA_W-1:STACK_W])));

   // R2
   status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pop_en && !push_en) |=> (status_q == $past(wdata)));
endmodule

// File: rtl/cop0_cause_reg.sv
module cop0_cause_reg
   import cop0_exc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SW_LO    = 8,
   parameter int unsigned SW_W     = 2,
   parameter int unsigned CD_LO    = 2,
   parameter int unsigned CD_W     = 5,
   parameter int unsigned BD_BIT   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SW_W-1:0]   wr_swi,
   input  logic              entry_en,
   input  logic [CD_W-1:0]   entry_code,
   input  logic              entry_bd,
   output logic [DATA_W-1:0] cause_q
);
   localparam int unsigned SW_HI = SW_LO + SW_W - 1;
   localparam int unsigned CD_HI = CD_LO + CD_W - 1;

   generate
      if (SW_HI >= DATA_W || CD_HI >= DATA_W || BD_BIT >= DATA_W) begin : g_bad_fields
         $error("cop0_cause_reg: a field lies outside the register");
      end
      if (CD_HI >= SW_LO) begin : g_overlap
         $error("cop0_cause_reg: code field overlaps software bits");
      end
   endgenerate

   logic [DATA_W-1:0] cause_d;

   always_comb begin
      cause_d = cause_q;
      if (entry_en) begin
         cause_d[CD_HI:CD_LO] = entry_code;
         cause_d[BD_BIT]      = entry_bd;
      end else if (wr_en) begin
         cause_d[SW_HI:SW_LO] = wr_swi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_d;
   end

   // R3
   cause_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !entry_en) |=>
         (cause_q[SW_HI:SW_LO] == $past(wr_swi)) &&
         (cause_q[SW_LO-1:0] == $past(cause_q[SW_LO-1:0])) &&
         (cause_q[DATA_W-1:SW_HI+1] == $past(cause_q[DATA_W-1:SW_HI+1])));

   // R9
   cause_bd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_en |=> (cause_q[BD_BIT] == $past(entry_bd)));
endmodule

// File: rtl/cop0_exc_seq.sv
module cop0_exc_seq
   import cop0_exc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SW_W    = 2,
   parameter int unsigned CD_W    = 5,
   parameter logic [31:0] VEC_RAM  = 32'h8000_0080,
   parameter logic [31:0] VEC_BOOT = 32'hBFC0_0180,
   parameter logic [31:0] SLOT_BYTES = 32'd4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brk_i,
   input  logic              recheck_arm,
   input  logic [SW_W-1:0]   swi_pend,
   input  logic [SW_W-1:0]   swi_mask,
   input  logic              ie_cur,
   input  logic              boot_vec,
   input  logic [DATA_W-1:0] pc_i,
   input  logic              in_delay_i,
   output logic              entry_en,
   output logic [CD_W-1:0]   entry_code,
   output logic              entry_bd,
   output logic              exc_taken_o,
   output logic [DATA_W-1:0] exc_vector_o,
   output logic [DATA_W-1:0] epc_o
);
   logic        recheck_q;
   logic        swi_hit;
   entry_kind_e kind;
   logic [DATA_W-1:0] ret_addr;

   assign swi_hit = recheck_q && ie_cur && ((swi_pend & swi_mask) != '0);

   always_comb begin
      if (brk_i)        kind = ENTRY_BRK;
      else if (swi_hit) kind = ENTRY_SWI;
      else              kind = ENTRY_NONE;
   end

   assign entry_en   = (kind != ENTRY_NONE);
   assign entry_code = (kind == ENTRY_BRK) ? CODE_BRK : CODE_INT;
   assign entry_bd   = in_delay_i;
   assign ret_addr   = in_delay_i ? (pc_i - SLOT_BYTES[DATA_W-1:0]) : pc_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         recheck_q    <= 1'b0;
         exc_taken_o  <= 1'b0;
         exc_vector_o <= '0;
         epc_o        <= '0;
      end else begin
         recheck_q   <= recheck_arm && !entry_en;
         exc_taken_o <= entry_en;
         if (entry_en) begin
            epc_o        <= ret_addr;
            exc_vector_o <= boot_vec ? VEC_BOOT[DATA_W-1:0] : VEC_RAM[DATA_W-1:0];
         end
      end
   end

   // R8
   brk_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_i |-> (entry_en && entry_code == CODE_BRK));

   // R7
   swi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_en && !brk_i) |-> (entry_code == CODE_INT));

   // R6
   no_spurious_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_en && !brk_i) |-> (recheck_q && ie_cur));
endmodule

// File: rtl/cop0_exc_ctrl.sv
module cop0_exc_ctrl
   import cop0_exc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned STATUS_IDX = 12,
   parameter int unsigned CAUSE_IDX  = 13,
   parameter int unsigned EPC_IDX    = 14,
   parameter logic [31:0] STATUS_RST = 32'h0040_0000,
   parameter bit          READ_FLOP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rfe_i,
   input  logic              brk_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic              in_delay_i,
   output logic              exc_taken_o,
   output logic [DATA_W-1:0] exc_vector_o,
   output logic [DATA_W-1:0] epc_o
);
   localparam int unsigned SW_HI = SWI_LO + SWI_W - 1;

   generate
      if (DATA_W != WORD_W) begin : g_bad_width
         $error("cop0_exc_ctrl: DATA_W must equal the machine word width");
      end
      if (STATUS_IDX >= (1 << ADDR_W) || CAUSE_IDX >= (1 << ADDR_W) ||
          EPC_IDX >= (1 << ADDR_W)) begin : g_bad_idx
         $error("cop0_exc_ctrl: register index does not fit ADDR_W");
      end
   endgenerate

   logic [DATA_W-1:0] status_q, cause_q;
   logic              wr_status, wr_cause;
   logic              entry_en, entry_bd;
   logic [CODE_W-1:0] entry_code;
   logic [DATA_W-1:0] rd_mux;

   assign wr_status = reg_wr_en && !rfe_i && (reg_addr == ADDR_W'(STATUS_IDX));
   assign wr_cause  = reg_wr_en && !rfe_i && (reg_addr == ADDR_W'(CAUSE_IDX));

   cop0_status_reg #(
      .DATA_W  (DATA_W),
      .STACK_W (STK_W),
      .RST_VAL (STATUS_RST)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_status),
      .wdata    (reg_wdata),
      .pop_en   (rfe_i),
      .push_en  (entry_en),
      .status_q (status_q)
   );

   cop0_cause_reg #(
      .DATA_W (DATA_W),
      .SW_LO  (SWI_LO),
      .SW_W   (SWI_W),
      .CD_LO  (CODE_LO),
      .CD_W   (CODE_W),
      .BD_BIT (BD_POS)
   ) u_cause (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_cause),
      .wr_swi     (reg_wdata[SW_HI:SWI_LO]),
      .entry_en   (entry_en),
      .entry_code (entry_code),
      .entry_bd   (entry_bd),
      .cause_q    (cause_q)
   );

   cop0_exc_seq #(
      .DATA_W (DATA_W),
      .SW_W   (SWI_W),
      .CD_W   (CODE_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .brk_i        (brk_i),
      .recheck_arm  (wr_cause || rfe_i),
      .swi_pend     (cause_q[SW_HI:SWI_LO]),
      .swi_mask     (status_q[SW_HI:SWI_LO]),
      .ie_cur       (status_q[0]),
      .boot_vec     (status_q[BEV_POS]),
      .pc_i         (pc_i),
      .in_delay_i   (in_delay_i),
      .entry_en     (entry_en),
      .entry_code   (entry_code),
      .entry_bd     (entry_bd),
      .exc_taken_o  (exc_taken_o),
      .exc_vector_o (exc_vector_o),
      .epc_o        (epc_o)
   );

   always_comb begin
      if (reg_addr == ADDR_W'(STATUS_IDX))     rd_mux = status_q;
      else if (reg_addr == ADDR_W'(CAUSE_IDX)) rd_mux = cause_q;
      else if (reg_addr == ADDR_W'(EPC_IDX))   rd_mux = epc_o;
      else                                     rd_mux = '0;
   end

   generate
      if (READ_FLOP) begin : g_rd_flop
         always_ff @(posedge clk) begin
            if (!rst_n) reg_rdata <= '0;
            else        reg_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   // R9
   epc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken_o |-> (epc_o == ($past(in_delay_i) ? ($past(pc_i) - 32'd4) : $past(pc_i))));

   // R4
   epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_taken_o |-> $stable(epc_o));

   // R11
   vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken_o |-> (exc_vector_o == ($past(status_q[BEV_POS]) ? 32'hBFC0_0180 : 32'h8000_0080)));

   // R12
   entry_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_en && reg_wr_en) |=> exc_taken_o && (status_q[DATA_W-1:STK_W] == $past(status_q[DATA_W-1:STK_W])));
endmodule

// File: tb/cop0_exc_ctrl_bench.sv
module cop0_exc_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        rfe_i, brk_i, in_delay_i;
   logic [31:0] pc_i;
   logic        exc_taken_o;
   logic [31:0] exc_vector_o, epc_o;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   string tag = "R1";

   logic [31:0] m_status, m_cause, m_epc, m_vec;
   logic        m_taken, m_recheck;

   always #4 clk = ~clk;

   cop0_exc_ctrl u_cop0_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rfe_i(rfe_i), .brk_i(brk_i),
      .pc_i(pc_i), .in_delay_i(in_delay_i), .exc_taken_o(exc_taken_o),
      .exc_vector_o(exc_vector_o), .epc_o(epc_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [4:0] a);
      if (a == 5'd12) return m_status;
      if (a == 5'd13) return m_cause;
      if (a == 5'd14) return m_epc;
      return 32'h0;
   endfunction

   task automatic step();
      bit take_b, take_i;
      @(posedge clk);
      take_b = brk_i;
      take_i = !brk_i && m_recheck && ((m_cause & m_status & 32'h300) != 0) && m_status[0];
      if (take_b || take_i) begin
         m_epc        = in_delay_i ? pc_i - 32'd4 : pc_i;
         m_cause[31]  = in_delay_i;
         m_cause[6:2] = take_b ? 5'd9 : 5'd0;
         m_vec        = m_status[22] ? 32'hBFC0_0180 : 32'h8000_0080;
         m_status[5:0] = {m_status[3:0], 2'b00};
         m_taken      = 1'b1;
         m_recheck    = 1'b0;
      end else begin
         m_taken   = 1'b0;
         m_recheck = 1'b0;
         if (rfe_i) begin
            m_status[3:0] = m_status[5:2];
            m_recheck = 1'b1;
         end else if (reg_wr_en) begin
            if (reg_addr == 5'd12) m_status = reg_wdata;
            if (reg_addr == 5'd13) begin
               m_cause[9:8] = reg_wdata[9:8];
               m_recheck = 1'b1;
            end
         end
      end
      @(negedge clk);
      chk("exc_taken", {31'd0, exc_taken_o}, {31'd0, m_taken});
      chk("epc", epc_o, m_epc);
      chk("rdata", reg_rdata, m_read(reg_addr));
      if (m_taken) chk("vector", exc_vector_o, m_vec);
   endtask

   task automatic idle(logic [4:0] rd);
      reg_wr_en = 0; rfe_i = 0; brk_i = 0; reg_addr = rd;
      step();
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      reg_wr_en = 1; reg_addr = a; reg_wdata = d; rfe_i = 0; brk_i = 0;
      step();
      reg_wr_en = 0;
   endtask

   task automatic read_all();
      idle(5'd12); idle(5'd13); idle(5'd14);
   endtask

   initial begin
      rst_n = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
      rfe_i = 0; brk_i = 0; pc_i = 32'h0000_1000; in_delay_i = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_status = 32'h0040_0000; m_cause = 0; m_epc = 0; m_vec = 0;
      m_taken = 0; m_recheck = 0;

      tag = "R1";
      chk("reset taken", {31'd0, exc_taken_o}, 32'd0);
      read_all();
      idle(5'd3);

      tag = "R2";
      wr(5'd12, 32'h1234_0002);
      read_all();

      tag = "R3";
      wr(5'd13, 32'hFFFF_FFFF);
      read_all();
      wr(5'd13, 32'h0000_0000);
      idle(5'd13);

      tag = "R4";
      wr(5'd14, 32'hDEAD_BEEF);
      idle(5'd14);

      tag = "R6";
      wr(5'd13, 32'h0000_0100);
      idle(5'd13);
      wr(5'd12, 32'h0000_0301);
      idle(5'd12); idle(5'd12);
      pc_i = 32'h0000_2000;
      tag = "R7";
      wr(5'd13, 32'h0000_0100);
      idle(5'd13);
      tag = "R10";
      idle(5'd13);
      read_all();

      tag = "R5";
      pc_i = 32'h0000_3000; in_delay_i = 1;
      reg_addr = 5'd12; rfe_i = 1; step(); rfe_i = 0;
      tag = "R9";
      idle(5'd12); idle(5'd13); idle(5'd14);
      in_delay_i = 0;

      tag = "R11";
      wr(5'd13, 32'h0);
      wr(5'd12, 32'h0040_0001);
      pc_i = 32'h0000_4000;
      tag = "R8";
      reg_addr = 5'd13; brk_i = 1; step(); brk_i = 0;
      read_all();

      tag = "R12";
      wr(5'd12, 32'h0000_0301);
      pc_i = 32'h0000_5000;
      reg_wr_en = 1; reg_addr = 5'd12; reg_wdata = 32'hFFFF_0000; brk_i = 1;
      step();
      reg_wr_en = 0; brk_i = 0;
      read_all();
      wr(5'd12, 32'h0000_0301);
      wr(5'd13, 32'h0000_0200);
      reg_addr = 5'd13; brk_i = 1; step(); brk_i = 0;
      idle(5'd13); idle(5'd13);
      reg_wr_en = 1; reg_addr = 5'd12; reg_wdata = 32'h0000_0000; rfe_i = 1;
      step();
      rfe_i = 0; reg_wr_en = 0;
      read_all(); idle(5'd12);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule